// File: doc/BRIEF.md
# Clock Generator Configuration Port (SMBus Block-Access Slave)

This block is the serial configuration port of a clock generator. It is an SMBus slave that runs from an oversampling system clock. Its 7-bit device address is `1101_1` followed by two strap inputs, so up to four generators can share one bus. The host programs the part with indexed block transfers. Each transfer names a starting register index and carries a byte count. On reads, the slave first returns a count and then the register bytes.

There are three registers. Index 0 is a control byte that holds a vendor test bit, a 3-bit multiplier code and four output enables. Index 1 is a spare read/write byte. Index 2 is a read-only identity byte. The control byte is combined with a global output-enable pin and a bypass strap to drive the per-output enables and the PLL/bypass mode. The multiplier code is exported unchanged.

The engine is one state machine with these states:
- `ST_IDLE`: waiting for a start.
- `ST_ADDR`, then `ST_ADDR_ACK`: address byte and its acknowledge.
- `ST_INDEX`, then `ST_INDEX_ACK`: index byte and its acknowledge.
- `ST_COUNT`, then `ST_COUNT_ACK`: count byte and its acknowledge.
- `ST_WDATA`, then `ST_WDATA_ACK`: write data byte and its acknowledge.
- `ST_TX`, then `ST_TX_ACK`: sending a byte, then sampling the host's acknowledge.
- `ST_SKIP`: ignoring the bus until the next start or stop.

Transitions:
- A stop leads from any state to `ST_IDLE`.
- A start or repeated start leads from any state to `ST_ADDR`.
- After eight bits, `ST_ADDR` goes to `ST_ADDR_ACK` on an address hit and to `ST_SKIP` on a miss.
- `ST_ADDR_ACK` goes to `ST_TX` for a read and to `ST_INDEX` for a write.
- `ST_INDEX_ACK` goes to `ST_COUNT`.
- `ST_COUNT_ACK` goes to `ST_WDATA`.
- After eight bits, `ST_WDATA` goes to `ST_WDATA_ACK` while count remains, otherwise to `ST_SKIP`.
- `ST_WDATA_ACK` returns to `ST_WDATA`.
- `ST_TX` goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK` goes back to `ST_TX` on a host ACK and to `ST_SKIP` on a NACK.

Each state advances on the falling edge of the filtered SCL.

Top module: `smbcfg_slave`

## Requirements
- R1: The address byte is `1101_1`, `addr_strap[1]`, `addr_strap[0]`, R/W (1 = read). The slave ACKs only a matching address. On a mismatch it NACKs and ignores the rest of the transfer, so no register changes.
- R2: A block write is: start, write address, index N, count X, then data bytes. Every byte is ACKed while count remains. Data bytes land in registers N, N+1, … in order.
- R3: Data bytes beyond the count X are NACKed and discarded. A count of 0 makes the first data byte NACKed.
- R4: A block read is: start, write address, index N, repeated start, read address. The slave then sends the count byte, followed by registers N, N+1, …. It keeps sending while the host ACKs and stops driving after a host NACK.
- R5: The count returned on a read is the last non-zero count written. It is 3 after reset. A written count of 0 leaves it unchanged.
- R6: Register 0 has this layout: bit 7 = test bit (`test_mode`), bits 6:4 = multiplier code (`mult_sel`), bits 3:0 = enables. Its reset value is 0x1F. `mult_sel` changes only after a write to register 0.
- R7: `out_en[i]` is 1 only when `oe_pin` is 1 and register 0 bit (3−i) is 1. Bit 3 enables output 0 and bit 0 enables output 3.
- R8: Register 1 is read/write and resets to 0x00. Register 2 reads `{REV_ID[4:0], VENDOR_ID[2:0]}` (0x15 by default) and ignores writes.
- R9: An index of 3 or above reads as 0x00 and ignores writes.
- R10: `pll_mode` is 1 (PLL) when `bypass_n` is high and 0 (reference fanned out directly) when it is low.
- R11: SDA is open-drain. `sda_oe` = 1 pulls the line low. It is 0 after reset and in `ST_IDLE`, and it only rises while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line level |
| sda_i | input | 1 | SMBus data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| addr_strap | input | 2 | Low two address bits |
| oe_pin | input | 1 | Global output enable, active high |
| bypass_n | input | 1 | 0 = bypass, 1 = PLL mode |
| out_en | output | 4 | Per-output enable; 0 = high impedance |
| mult_sel | output | 3 | Multiplier code, exported unchanged |
| test_mode | output | 1 | Vendor test bit from register 0 |
| pll_mode | output | 1 | 1 = PLL path, 0 = bypass |

## Verification
The assertions take for granted that SCL stays at each level for longer than the synchronizer plus glitch filter (five system cycles by default). They also assume that SDA changes only while SCL is low, except when the host makes a start or stop. Under those conditions, an acknowledge or data bit driven on a filtered SCL fall always begins while the bus SCL is already low. The bench keeps every SCL phase and every SDA setup at ten system cycles. It changes SDA only a full quarter-bit after SCL falls, and it issues starts and stops only after the slave has released the line.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_INDEX, ST_INDEX_ACK,
        ST_COUNT, ST_COUNT_ACK, ST_WDATA, ST_WDATA_ACK,
        ST_TX, ST_TX_ACK, ST_SKIP
    } smb_state_e;

    localparam int          REG_COUNT   = 3;
    localparam logic [4:0]  DEV_ADDR_HI = 5'b11011;
    localparam logic [7:0]  CTRL_RESET  = 8'h1F;
endpackage

// File: rtl/smbcfg_line_filter.sv
module smbcfg_line_filter #(
    parameter int STABLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(STABLE + 1);

    logic [1:0]    sync;
    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync  <= 2'b11;
            clean <= 1'b1;
            run   <= '0;
        end else begin
            sync <= {sync[0], raw};
            if (sync[1] == clean) begin
                run <= '0;
            end else if (run == CW'(STABLE - 1)) begin
                clean <= sync[1];
                run   <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smbcfg_regs.sv
module smbcfg_regs #(
    parameter logic [4:0] REV_ID    = 5'h02,
    parameter logic [2:0] VENDOR_ID = 3'h5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data,
    output logic [7:0] ctrl
);
    import smbcfg_pkg::*;

    logic [7:0] spare;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl  <= CTRL_RESET;
            spare <= 8'h00;
        end else if (wr_en) begin
            if (wr_idx == 8'd0) ctrl  <= wr_data;
            if (wr_idx == 8'd1) spare <= wr_data;
        end
    end

    always_comb begin
        unique case (rd_idx)
            8'd0:    rd_data = ctrl;
            8'd1:    rd_data = spare;
            8'd2:    rd_data = {REV_ID, VENDOR_ID};
            default: rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/smbcfg_fsm.sv
module smbcfg_fsm (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_f,
    input  logic                   sda_f,
    input  logic [1:0]             addr_strap,
    input  logic [7:0]             rd_data,
    output logic [7:0]             rd_idx,
    output logic                   wr_en,
    output logic [7:0]             wr_idx,
    output logic [7:0]             wr_data,
    output logic                   sda_oe,
    output smbcfg_pkg::smb_state_e state_o
);
    import smbcfg_pkg::*;

    smb_state_e state_q, state_d;
    logic       scl_q, sda_q;
    logic [7:0] sh, ptr, rem, cnt_q, txb;
    logic [3:0] bcnt;
    logic       host_ack;

    wire scl_rise = scl_f & ~scl_q;
    wire scl_fall = ~scl_f & scl_q;
    wire start_ev = scl_f & scl_q & sda_q & ~sda_f;
    wire stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
    wire byte_end = scl_fall && (bcnt == 4'd8);
    wire addr_hit = (sh[7:1] == {DEV_ADDR_HI, addr_strap});

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_ADDR:      if (byte_end) state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall) state_d = sh[0] ? ST_TX : ST_INDEX;
                ST_INDEX:     if (byte_end) state_d = ST_INDEX_ACK;
                ST_INDEX_ACK: if (scl_fall) state_d = ST_COUNT;
                ST_COUNT:     if (byte_end) state_d = ST_COUNT_ACK;
                ST_COUNT_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_WDATA:     if (byte_end) state_d = (rem != 8'd0) ? ST_WDATA_ACK : ST_SKIP;
                ST_WDATA_ACK: if (scl_fall) state_d = ST_WDATA;
                ST_TX:        if (byte_end) state_d = ST_TX_ACK;
                ST_TX_ACK:    if (scl_fall) state_d = host_ack ? ST_TX : ST_SKIP;
                ST_SKIP:      state_d = ST_SKIP;
                default:      state_d = ST_IDLE;
            endcase
        end
    end

    // byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            sh       <= '0;
            ptr      <= '0;
            rem      <= '0;
            cnt_q    <= 8'(REG_COUNT);
            txb      <= '0;
            bcnt     <= '0;
            host_ack <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
            wr_en <= 1'b0;
            if (start_ev || stop_ev) begin
                bcnt <= '0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                        if (scl_rise) begin
                            sh   <= {sh[6:0], sda_f};
                            bcnt <= bcnt + 4'd1;
                        end
                        if (byte_end && state_q == ST_INDEX) ptr <= sh;
                        if (byte_end && state_q == ST_COUNT) begin
                            rem <= sh;
                            if (sh != 8'd0) cnt_q <= sh;
                        end
                        if (byte_end && state_q == ST_WDATA && rem != 8'd0) begin
                            wr_en   <= 1'b1;
                            wr_idx  <= ptr;
                            wr_data <= sh;
                            ptr     <= ptr + 8'd1;
                            rem     <= rem - 8'd1;
                        end
                    end
                    ST_ADDR_ACK, ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            bcnt <= '0;
                            if (state_q == ST_ADDR_ACK && sh[0]) txb <= cnt_q;
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bcnt <= bcnt + 4'd1;
                        if (scl_fall && bcnt != 4'd8) txb <= {txb[6:0], 1'b0};
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) host_ack <= ~sda_f;
                        if (scl_fall) begin
                            bcnt <= '0;
                            txb  <= rd_data;
                            ptr  <= ptr + 8'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_TX:   sda_oe = ~txb[7];
            default: sda_oe = 1'b0;
        endcase
        rd_idx  = ptr;
        state_o = state_q;
    end
endmodule

// File: rtl/smbcfg_slave.sv
module smbcfg_slave #(
    parameter int         FILT_LEN  = 3,
    parameter logic [4:0] REV_ID    = 5'h02,
    parameter logic [2:0] VENDOR_ID = 3'h5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] addr_strap,
    input  logic       oe_pin,
    input  logic       bypass_n,
    output logic [3:0] out_en,
    output logic [2:0] mult_sel,
    output logic       test_mode,
    output logic       pll_mode
);
    import smbcfg_pkg::*;

    localparam int NUM_OUT = 4;

    logic       scl_f, sda_f;
    logic       wr_en;
    logic [7:0] wr_idx, wr_data, rd_idx, rd_data, ctrl;
    smb_state_e fsm_state;

    smbcfg_line_filter #(.STABLE(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .raw(scl_i), .clean(scl_f));
    smbcfg_line_filter #(.STABLE(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .raw(sda_i), .clean(sda_f));

    smbcfg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .addr_strap(addr_strap), .rd_data(rd_data), .rd_idx(rd_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .sda_oe(sda_oe), .state_o(fsm_state));

    smbcfg_regs #(.REV_ID(REV_ID), .VENDOR_ID(VENDOR_ID)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .ctrl(ctrl));

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_oe
        assign out_en[i] = oe_pin & ctrl[NUM_OUT-1-i];
    end

    assign mult_sel  = ctrl[6:4];
    assign test_mode = ctrl[7];
    assign pll_mode  = bypass_n;
endmodule

// File: rtl/smbcfg_slave_chk.sv
module smbcfg_slave_chk (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   scl_i,
    input logic                   sda_oe,
    input logic                   oe_pin,
    input logic [3:0]             out_en,
    input logic [2:0]             mult_sel,
    input logic                   wr_en,
    input smbcfg_pkg::smb_state_e state
);
    import smbcfg_pkg::*;

    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_pin |-> out_en == 4'b0000);

    p_mult_only_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mult_sel) |-> $past(wr_en));

    p_write_acked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);

    p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> !sda_oe);

    p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);
endmodule

bind smbcfg_slave smbcfg_slave_chk chk_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .oe_pin(oe_pin), .out_en(out_en), .mult_sel(mult_sel),
    .wr_en(wr_en), .state(fsm_state));

// File: tb/smbcfg_slave_tb.sv
module smbcfg_slave_tb_top;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1, sda_host = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       oe_pin = 1'b1, byp_n = 1'b1;
    logic       sda_oe, test_mode, pll_mode;
    logic [3:0] out_en;
    logic [2:0] mult_sel;
    wire        sda_line = sda_host & ~sda_oe;

    int compared = 0, mismatched = 0;
    logic [7:0] rb [0:3];

    always #10 clk = ~clk;

    smbcfg_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_strap(strap), .oe_pin(oe_pin),
        .bypass_n(byp_n), .out_en(out_en), .mult_sel(mult_sel),
        .test_mode(test_mode), .pll_mode(pll_mode));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_host = 1; scl_drv = 1; q(); sda_host = 0; q(); scl_drv = 0; q();
    endtask
    task automatic bus_rstart();
        sda_host = 1; q(); scl_drv = 1; q(); sda_host = 0; q(); scl_drv = 0; q();
    endtask
    task automatic bus_stop();
        sda_host = 0; q(); scl_drv = 1; q(); sda_host = 1; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic nack);
        for (int i = 7; i >= 0; i--) begin
            sda_host = b[i]; q(); scl_drv = 1; q(); q(); scl_drv = 0; q();
        end
        sda_host = 1; q(); scl_drv = 1; q(); nack = sda_line; q(); scl_drv = 0; q();
    endtask

    task automatic recv_byte(input logic host_nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_host = 1; q(); scl_drv = 1; q(); b[i] = sda_line; q(); scl_drv = 0; q();
        end
        sda_host = host_nack; q(); scl_drv = 1; q(); q(); scl_drv = 0; q();
    endtask

    // nk: [0] address, [1] index, [2] count, [3] data0, [4] data1
    task automatic blk_write(input logic [7:0] adr, input logic [7:0] idx,
                             input logic [7:0] cnt, input logic [7:0] d0,
                             input logic [7:0] d1, input int n, output logic [4:0] nk);
        nk = '1;
        bus_start();
        send_byte(adr, nk[0]);
        if (!nk[0]) begin
            send_byte(idx, nk[1]);
            send_byte(cnt, nk[2]);
            if (n > 0) send_byte(d0, nk[3]);
            if (n > 1) send_byte(d1, nk[4]);
        end
        bus_stop();
    endtask

    // rb[0] = count byte, rb[1..n] = data bytes
    task automatic blk_read(input logic [7:0] adr, input logic [7:0] idx, input int n);
        logic nk;
        bus_start();
        send_byte(adr, nk);
        send_byte(idx, nk);
        bus_rstart();
        send_byte(adr | 8'h01, nk);
        recv_byte(1'b0, rb[0]);
        for (int i = 1; i <= n; i++) recv_byte(i == n, rb[i]);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R6 ctrl reset mult", mult_sel, 3'b001);
        check("R6 ctrl reset test", test_mode, 1'b0);
        check("R7 reset enables", out_en, 4'b1111);
        check("R11 sda released", sda_oe, 1'b0);
        check("R10 pll mode", pll_mode, 1'b1);
        blk_read(8'hDA, 8'd0, 3);
        check("R5 default count", rb[0], 8'd3);
        check("R4 read reg0", rb[1], 8'h1F);
        check("R8 reg1 reset", rb[2], 8'h00);
        check("R8 id byte", rb[3], 8'h15);
        check("R11 release after read", sda_oe, 1'b0);
    endtask

    task automatic t_write();
        logic [4:0] nk;
        blk_write(8'hDA, 8'd0, 8'd2, 8'h5A, 8'hC3, 2, nk);
        check("R2 write acks", nk, 5'b00000);
        @(negedge clk);
        check("R6 mult after write", mult_sel, 3'b101);
        check("R7 enables after write", out_en, 4'b0101);
        blk_read(8'hDA, 8'd0, 2);
        check("R5 stored count", rb[0], 8'd2);
        check("R2 reg0 data", rb[1], 8'h5A);
        check("R2 reg1 data", rb[2], 8'hC3);
    endtask

    task automatic t_readonly();
        logic [4:0] nk;
        blk_write(8'hDA, 8'd2, 8'd1, 8'hFF, 8'h00, 1, nk);
        check("R8 ro write acked", nk[3:0], 4'b0000);
        blk_read(8'hDA, 8'd2, 1);
        check("R5 count 1", rb[0], 8'd1);
        check("R8 ro unchanged", rb[1], 8'h15);
    endtask

    task automatic t_overflow();
        logic [4:0] nk;
        blk_write(8'hDA, 8'd0, 8'd1, 8'h9F, 8'h77, 2, nk);
        check("R3 first data ack", nk[3], 1'b0);
        check("R3 extra data nack", nk[4], 1'b1);
        @(negedge clk);
        check("R6 test bit", test_mode, 1'b1);
        blk_read(8'hDA, 8'd0, 2);
        check("R2 reg0 new", rb[1], 8'h9F);
        check("R3 reg1 untouched", rb[2], 8'hC3);
    endtask

    task automatic t_zero_count();
        logic [4:0] nk;
        blk_write(8'hDA, 8'd1, 8'd0, 8'h44, 8'h00, 1, nk);
        check("R3 zero count nack", nk[3], 1'b1);
        blk_read(8'hDA, 8'd1, 1);
        check("R5 count kept", rb[0], 8'd1);
        check("R3 reg1 kept", rb[1], 8'hC3);
    endtask

    task automatic t_range();
        logic [4:0] nk;
        blk_write(8'hDA, 8'd3, 8'd1, 8'hAB, 8'h00, 1, nk);
        blk_read(8'hDA, 8'd3, 2);
        check("R9 idx3 reads zero", rb[1], 8'h00);
        check("R9 idx4 reads zero", rb[2], 8'h00);
    endtask

    task automatic t_address();
        logic [4:0] nk;
        strap = 2'b11;
        blk_write(8'hD8, 8'd0, 8'd1, 8'h00, 8'h00, 1, nk);
        check("R1 miss nack", nk[0], 1'b1);
        @(negedge clk);
        check("R1 miss no write", out_en, 4'b1111);
        blk_write(8'hDE, 8'd1, 8'd1, 8'h3C, 8'h00, 1, nk);
        check("R1 hit acks", nk[3:0], 4'b0000);
        blk_read(8'hDE, 8'd1, 1);
        check("R1 read at DF", rb[1], 8'h3C);
    endtask

    task automatic t_pins();
        oe_pin = 0; byp_n = 0;
        repeat (2) @(negedge clk);
        check("R7 oe low", out_en, 4'b0000);
        check("R10 bypass", pll_mode, 1'b0);
        oe_pin = 1; byp_n = 1;
        repeat (2) @(negedge clk);
        check("R7 oe high", out_en, 4'b1111);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write();
        t_readonly();
        t_overflow();
        t_zero_count();
        t_range();
        t_address();
        t_pins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule